// File: doc/BRIEF.md
# Blocking Four-Way Data Cache

This block is a data cache that sits between the memory stage of an in-order pipeline and a block-wide backing memory. The pipeline presents one aligned 32-bit word load or store per request. The request carries a 32-bit physical byte address. A hit completes in the cycle it is presented: load data comes back combinationally and `stall` stays low. A miss raises `stall` in that same cycle. The pipeline must then hold its request unchanged until `stall` drops, and the held request then completes as a hit.

The cache holds 16384 bytes in 16-byte blocks across 4 ways, which gives 256 sets. Replacement follows true least-recently-used order. Each way in a set carries a 2-bit age, and 0 marks the most recent way. Stores are write-back and write-allocate. A store miss first fetches the block, then merges the store word and marks the block dirty. Memory sees data only when a dirty block is chosen as a victim. In that case a write-back phase of fixed length runs before the refill. Both phase lengths are parameters with a default of 20 cycles.

The memory side uses a request/acknowledge pair that moves whole 128-bit blocks. Each phase lasts its fixed number of cycles. The phase closes on its last cycle only if the acknowledge is high.

Top module: `dcache_top`

## Requirements
- R1: After reset every block is invalid, `stall` and `mem_req` are low while no request is presented, and the first access to any address is a miss.
- R2: An address splits into a 20-bit tag (bits 31:12), an 8-bit set index (bits 11:4) and a 4-bit block offset, with bits 3:2 choosing the word. Four blocks that share an index coexist in the cache.
- R3: A load hit keeps `stall` low and returns the last value written to that word.
- R4: A miss whose victim is clean or invalid holds `stall` high for exactly FILL_CYC (20) cycles. The request then completes as a hit.
- R5: A miss whose victim is valid and dirty holds `stall` high for WB_CYC + FILL_CYC (40) cycles. During that time the victim block is written to memory at its own block address, and it carries the latest stored words.
- R6: When all four ways of a set are valid, a miss replaces the way that was touched least recently. A touch is either a hit or a fill.
- R7: Store hits and fills never write to memory. Memory is written only during a dirty eviction.
- R8: A store miss allocates the block. Later loads return the stored word for that word and the memory contents for the other words of the block.
- R9: An invalid way in the set is always filled before any valid way is evicted.
- R10: `mem_req` is high only while `stall` is high, and `mem_addr` is always block aligned (bits 3:0 zero). `mem_we` marks the write-back phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A word access is presented |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Physical byte address, word aligned |
| req_wdata | input | 32 | Store data |
| rsp_rdata | output | 32 | Load data, valid when a load is presented and `stall` is low |
| stall | output | 1 | Pipeline must hold its request |
| mem_req | output | 1 | Block transfer in progress |
| mem_we | output | 1 | 1 = block write-back, 0 = block read |
| mem_addr | output | 32 | Block-aligned memory address |
| mem_wdata | output | 128 | Victim block being written back |
| mem_rdata | input | 128 | Block returned by memory |
| mem_ack | input | 1 | Memory accepts or delivers the block |

## Verification
A corrupted tag, valid bit or age shows up at the ports through the stall length of the next access to that set. A hit that should last 0 cycles becomes 20, or a clean 20-cycle miss becomes 40. A wrong victim choice shows up only once the evicted block is touched again, when its stall count differs from the prediction. A lost dirty bit or a wrong write-back address shows up at the eviction itself through the memory write. A lost store word shows up only on the first load from that word after a refill from memory. For that reason the bench predicts the hit, the victim and the write-back for every access with its own set model, and compares them on that same access.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_WRBK = 2'd1,
    CS_FILL = 2'd2
  } cstate_e;
endpackage

// File: rtl/dcache_arrays.sv
module dcache_arrays #(
  parameter int SETS  = 256,
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  parameter int BLK_W = 128
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(SETS)-1:0]      rd_set,
  output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
  output logic [WAYS-1:0][BLK_W-1:0]   rd_data,
  output logic [WAYS-1:0]              rd_valid,
  output logic [WAYS-1:0]              rd_dirty,
  input  logic                         wr_en,
  input  logic [$clog2(SETS)-1:0]      wr_set,
  input  logic [$clog2(WAYS)-1:0]      wr_way,
  input  logic [TAG_W-1:0]             wr_tag,
  input  logic [BLK_W-1:0]             wr_data,
  input  logic                         wr_dirty
);
  localparam int SW = $clog2(SETS);
  localparam int WW = $clog2(WAYS);
  localparam int LINES = SETS * WAYS;

  logic [BLK_W-1:0] data_m  [LINES];
  logic [TAG_W-1:0] tag_m   [LINES];
  logic [WAYS-1:0]  valid_m [SETS];
  logic [WAYS-1:0]  dirty_m [SETS];

  function automatic int unsigned line_of(logic [SW-1:0] s, logic [WW-1:0] w);
    return int'({s, w});
  endfunction

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_rd
      assign rd_tag[g]  = tag_m[line_of(rd_set, WW'(g))];
      assign rd_data[g] = data_m[line_of(rd_set, WW'(g))];
    end
  endgenerate
  assign rd_valid = valid_m[rd_set];
  assign rd_dirty = dirty_m[rd_set];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_m[line_of(wr_set, wr_way)] <= wr_data;
      tag_m[line_of(wr_set, wr_way)]  <= wr_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_m[s] <= '0;
        dirty_m[s] <= '0;
      end
    end else if (wr_en) begin
      valid_m[wr_set][wr_way] <= 1'b1;
      dirty_m[wr_set][wr_way] <= wr_dirty;
    end
  end

  // R7
  clean_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_dirty) |=> !dirty_m[$past(wr_set)][$past(wr_way)]);
endmodule

// File: rtl/dcache_lru.sv
module dcache_lru #(
  parameter int SETS = 256,
  parameter int WAYS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    touch,
  input  logic [$clog2(SETS)-1:0] touch_set,
  input  logic [$clog2(WAYS)-1:0] touch_way,
  input  logic [$clog2(SETS)-1:0] rd_set,
  output logic [$clog2(WAYS)-1:0] oldest_way
);
  localparam int SW    = $clog2(SETS);
  localparam int WW    = $clog2(WAYS);
  localparam int AGE_W = WW;

  logic [AGE_W-1:0] age [SETS][WAYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age[s][w] <= AGE_W'(w);
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WW'(w) == touch_way)
          age[touch_set][w] <= '0;
        else if (age[touch_set][w] < age[touch_set][touch_way])
          age[touch_set][w] <= age[touch_set][w] + AGE_W'(1);
      end
    end
  end

  always_comb begin
    oldest_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (age[rd_set][w] == AGE_W'(WAYS - 1)) oldest_way = WW'(w);
  end

  // named events for the checks below
  logic          t_q;
  logic [SW-1:0] ts_q;
  logic [WW-1:0] tw_q;
  logic [WAYS-1:0] perm_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q  <= 1'b0;
      ts_q <= '0;
      tw_q <= '0;
    end else begin
      t_q  <= touch;
      ts_q <= touch_set;
      tw_q <= touch_way;
    end
  end

  always_comb begin
    perm_mask = '0;
    for (int w = 0; w < WAYS; w++) perm_mask[age[rd_set][w]] = 1'b1;
  end

  // R6
  mru_after_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_q |-> (age[ts_q][tw_q] == '0));
  // R6
  age_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    &perm_mask);
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int WB_CYC   = 20,
  parameter int FILL_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic miss,
  input  logic victim_dirty,
  input  logic mem_ack,
  output logic busy,
  output logic capture,
  output logic wb_phase,
  output logic fill_phase,
  output logic fill_done
);
  localparam int MAXC = (WB_CYC > FILL_CYC) ? WB_CYC : FILL_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  cstate_e       st;
  logic [CW-1:0] cnt;
  logic          wb_last;

  assign busy       = (st != CS_IDLE);
  assign capture    = (st == CS_IDLE) && miss;
  assign wb_phase   = (st == CS_WRBK);
  assign fill_phase = (st == CS_FILL);
  assign wb_last    = wb_phase && (cnt == CW'(WB_CYC - 1)) && mem_ack;
  assign fill_done  = fill_phase && (cnt == CW'(FILL_CYC - 1)) && mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= CS_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        CS_IDLE: if (miss) begin
          st  <= victim_dirty ? CS_WRBK : CS_FILL;
          cnt <= CW'(1);
        end
        CS_WRBK: begin
          if (wb_last) begin
            st  <= CS_FILL;
            cnt <= '0;
          end else if (cnt != CW'(WB_CYC - 1)) begin
            cnt <= cnt + CW'(1);
          end
        end
        CS_FILL: begin
          if (fill_done) begin
            st  <= CS_IDLE;
            cnt <= '0;
          end else if (cnt != CW'(FILL_CYC - 1)) begin
            cnt <= cnt + CW'(1);
          end
        end
        default: st <= CS_IDLE;
      endcase
    end
  end

  // R5
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_last |=> (fill_phase && cnt == '0));
  // R4
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_phase |-> (cnt <= CW'(FILL_CYC - 1)));
  // R4
  fill_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !busy);
endmodule

// File: rtl/dcache_top.sv
module dcache_top #(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int CAPACITY    = 16384,
  parameter int BLOCK_BYTES = 16,
  parameter int WAYS        = 4,
  parameter int FILL_CYC    = 20,
  parameter int WB_CYC      = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [WORD_W-1:0]        req_wdata,
  output logic [WORD_W-1:0]        rsp_rdata,
  output logic                     stall,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [BLOCK_BYTES*8-1:0] mem_wdata,
  input  logic [BLOCK_BYTES*8-1:0] mem_rdata,
  input  logic                     mem_ack
);
  localparam int BLK_W   = BLOCK_BYTES * 8;
  localparam int SETS    = CAPACITY / (BLOCK_BYTES * WAYS);
  localparam int OFF_W   = $clog2(BLOCK_BYTES);
  localparam int IDX_W   = $clog2(SETS);
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
  localparam int WW      = $clog2(WAYS);
  localparam int WPB     = BLK_W / WORD_W;
  localparam int WSEL_W  = $clog2(WPB);
  localparam int BYTE_SH = $clog2(WORD_W / 8);

  // address arithmetic
  function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [IDX_W-1:0] idx_of(logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [WSEL_W-1:0] wsel_of(logic [ADDR_W-1:0] a);
    return a[BYTE_SH +: WSEL_W];
  endfunction
  function automatic logic [ADDR_W-1:0] blk_addr(logic [TAG_W-1:0] t, logic [IDX_W-1:0] i);
    return {t, i, {OFF_W{1'b0}}};
  endfunction
  function automatic logic [BLK_W-1:0] put_word(logic [BLK_W-1:0] b, logic [WSEL_W-1:0] s,
                                                logic [WORD_W-1:0] d);
    logic [BLK_W-1:0] r;
    r = b;
    r[int'(s) * WORD_W +: WORD_W] = d;
    return r;
  endfunction

  // held miss
  logic [ADDR_W-1:0] mq_addr;
  logic              mq_we;
  logic [WORD_W-1:0] mq_wdata;
  logic [WW-1:0]     mq_way;
  logic [TAG_W-1:0]  mq_vtag;

  // control events
  logic busy, capture, wb_phase, fill_phase, fill_done;
  logic hit, miss, victim_dirty;

  // array read side
  logic [IDX_W-1:0]             look_set;
  logic [WAYS-1:0][TAG_W-1:0]   rd_tag;
  logic [WAYS-1:0][BLK_W-1:0]   rd_data;
  logic [WAYS-1:0]              rd_valid, rd_dirty;
  logic [WAYS-1:0]              hit_vec;
  logic [WW-1:0]                hit_way, oldest_way, victim_way;
  logic                         have_free;
  logic [WW-1:0]                free_way;

  // array write side
  logic              wr_en, wr_dirty;
  logic [IDX_W-1:0]  wr_set;
  logic [WW-1:0]     wr_way;
  logic [TAG_W-1:0]  wr_tag;
  logic [BLK_W-1:0]  wr_data;

  assign look_set = busy ? idx_of(mq_addr) : idx_of(req_addr);

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_cmp
      assign hit_vec[g] = rd_valid[g] && (rd_tag[g] == tag_of(req_addr));
    end
  endgenerate

  always_comb begin
    hit_way   = '0;
    free_way  = '0;
    have_free = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WW'(w);
      if (!rd_valid[w]) begin
        free_way  = WW'(w);
        have_free = 1'b1;
      end
    end
  end

  assign victim_way   = have_free ? free_way : oldest_way;
  assign victim_dirty = rd_valid[victim_way] && rd_dirty[victim_way];
  assign hit          = req_valid && !busy && (|hit_vec);
  assign miss         = req_valid && !busy && !(|hit_vec);
  assign stall        = busy || miss;
  assign rsp_rdata    = rd_data[hit_way][int'(wsel_of(req_addr)) * WORD_W +: WORD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq_addr  <= '0;
      mq_we    <= 1'b0;
      mq_wdata <= '0;
      mq_way   <= '0;
      mq_vtag  <= '0;
    end else if (capture) begin
      mq_addr  <= req_addr;
      mq_we    <= req_write;
      mq_wdata <= req_wdata;
      mq_way   <= victim_way;
      mq_vtag  <= rd_tag[victim_way];
    end
  end

  // memory side
  assign mem_req   = wb_phase || fill_phase;
  assign mem_we    = wb_phase;
  assign mem_addr  = wb_phase ? blk_addr(mq_vtag, idx_of(mq_addr))
                              : blk_addr(tag_of(mq_addr), idx_of(mq_addr));
  assign mem_wdata = rd_data[mq_way];

  // one write port: refill or store hit
  always_comb begin
    wr_en    = 1'b0;
    wr_set   = idx_of(req_addr);
    wr_way   = hit_way;
    wr_tag   = tag_of(req_addr);
    wr_data  = put_word(rd_data[hit_way], wsel_of(req_addr), req_wdata);
    wr_dirty = 1'b1;
    if (fill_done) begin
      wr_en    = 1'b1;
      wr_set   = idx_of(mq_addr);
      wr_way   = mq_way;
      wr_tag   = tag_of(mq_addr);
      wr_data  = mq_we ? put_word(mem_rdata, wsel_of(mq_addr), mq_wdata) : mem_rdata;
      wr_dirty = mq_we;
    end else if (hit && req_write) begin
      wr_en = 1'b1;
    end
  end

  dcache_arrays #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .rd_set(look_set), .rd_tag(rd_tag), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty), .wr_en(wr_en), .wr_set(wr_set),
    .wr_way(wr_way), .wr_tag(wr_tag), .wr_data(wr_data), .wr_dirty(wr_dirty)
  );

  dcache_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch(fill_done || hit),
    .touch_set(fill_done ? idx_of(mq_addr) : idx_of(req_addr)),
    .touch_way(fill_done ? mq_way : hit_way),
    .rd_set(look_set), .oldest_way(oldest_way)
  );

  dcache_ctrl #(.WB_CYC(WB_CYC), .FILL_CYC(FILL_CYC)) u_ctl (
    .clk(clk), .rst_n(rst_n), .miss(miss), .victim_dirty(victim_dirty), .mem_ack(mem_ack),
    .busy(busy), .capture(capture), .wb_phase(wb_phase), .fill_phase(fill_phase),
    .fill_done(fill_done)
  );

  // R10
  mem_req_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> stall);
  // R10
  mem_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0));
  // R2
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R4
  stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> $past(fill_done));
  // R9
  free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && have_free) |=> !mem_we);
endmodule

// File: tb/sim_dcache_top.sv
`timescale 1ns/1ps
module sim_dcache_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic stall, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dcache_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .stall(stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // backing memory
  logic [127:0] bmem [int unsigned];
  int unsigned wr_cnt = 0;
  logic [31:0] wr_addr = '0;
  logic [127:0] wr_data = '0;

  function automatic logic [31:0] init_word(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction
  function automatic logic [127:0] rd_blk(logic [31:0] ba);
    logic [127:0] b;
    if (bmem.exists(ba)) return bmem[ba];
    for (int i = 0; i < 4; i++) b[32*i +: 32] = init_word(ba + 32'(4*i));
    return b;
  endfunction

  assign mem_ack = mem_req;
  always @(posedge clk) begin
    if (mem_req && mem_we && mem_ack) begin
      bmem[mem_addr] = mem_wdata;
      wr_cnt  = wr_cnt + 1;
      wr_addr = mem_addr;
      wr_data = mem_wdata;
    end
    mem_rdata <= rd_blk(mem_addr);
  end

  // golden word values and set model
  logic [31:0] gold [int unsigned];
  logic [19:0] m_tag [256][4];
  bit          m_v   [256][4];
  bit          m_d   [256][4];
  int          m_age [256][4];

  function automatic logic [31:0] gword(logic [31:0] a);
    return gold.exists(a) ? gold[a] : init_word(a);
  endfunction

  task automatic model_touch(int s, int w);
    int a0 = m_age[s][w];
    for (int k = 0; k < 4; k++) if (m_age[s][k] < a0) m_age[s][k]++;
    m_age[s][w] = 0;
  endtask

  task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d, output int n);
    int s, hw, vw, en;
    bit ewb;
    logic [31:0] ewb_addr;
    int unsigned wr0;
    logic [127:0] expb;
    s = int'(a[11:4]);
    hw = -1; vw = -1; ewb = 0; ewb_addr = '0;
    for (int w = 0; w < 4; w++) if (m_v[s][w] && m_tag[s][w] == a[31:12]) hw = w;
    if (hw >= 0) begin
      en = 0;
    end else begin
      for (int w = 3; w >= 0; w--) if (!m_v[s][w]) vw = w;
      if (vw < 0) for (int w = 0; w < 4; w++) if (m_age[s][w] == 3) vw = w;
      ewb = m_v[s][vw] && m_d[s][vw];
      ewb_addr = {m_tag[s][vw], a[11:4], 4'h0};
      en = ewb ? 40 : 20;
      m_tag[s][vw] = a[31:12];
      m_v[s][vw] = 1;
      m_d[s][vw] = 0;
      hw = vw;
    end
    model_touch(s, hw);
    if (we) m_d[s][hw] = 1;

    wr0 = wr_cnt;
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
    #1;
    n = 0;
    while (stall && n < 100) begin
      n++;
      @(posedge clk); #1;
    end
    check(n == en, (en == 40) ? "R5" : ((en == 20) ? "R4" : "R3"), "stall cycles", 128'(n), 128'(en));
    if (!we) check(rsp_rdata == gword(a), "R3 R8", "load data", 128'(rsp_rdata), 128'(gword(a)));
    if (ewb) begin
      for (int i = 0; i < 4; i++) expb[32*i +: 32] = gword(ewb_addr + 32'(4*i));
      check(wr_cnt != wr0 && wr_addr == ewb_addr, "R5 R10", "writeback addr", 128'(wr_addr), 128'(ewb_addr));
      check(wr_data == expb, "R5", "writeback data", wr_data, expb);
    end else begin
      check(wr_cnt == wr0, "R7", "memory writes", 128'(wr_cnt - wr0), 128'(0));
    end
    if (we) gold[a] = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] a, d;
    void'($urandom(32'd4242));
    for (int s = 0; s < 256; s++)
      for (int w = 0; w < 4; w++) begin m_v[s][w] = 0; m_d[s][w] = 0; m_age[s][w] = w; end

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(stall == 1'b0 && mem_req == 1'b0, "R1", "idle outputs after reset",
          128'({stall, mem_req}), 128'(0));
    @(negedge clk);
    access(0, 32'h0000_0800, 0, n);
    check(n == 20, "R1", "first access misses", 128'(n), 128'(20));

    // loop-style pattern: two loads and a store per step
    for (int i = 0; i < 8; i++) begin
      a = 32'd2048 + 32'(4*i);
      access(0, a, 0, n);
      access(0, a + 32'd512, 0, n);
      access(1, a + 32'd4096, gword(a) + gword(a + 32'd512), n);
    end

    // R2 R9 R6: four tags into one fresh set, then replacement order
    for (int t = 1; t <= 4; t++) begin
      access(0, {20'(t), 8'h37, 4'h4}, 0, n);
      check(n == 20, "R9", "fill of free way", 128'(n), 128'(20));
    end
    for (int t = 1; t <= 4; t++) begin
      access(0, {20'(t), 8'h37, 4'h8}, 0, n);
      check(n == 0, "R2", "four blocks coexist", 128'(n), 128'(0));
    end
    access(0, {20'd1, 8'h37, 4'h0}, 0, n);
    access(0, {20'd9, 8'h37, 4'h0}, 0, n);
    access(0, {20'd1, 8'h37, 4'h0}, 0, n);
    check(n == 0, "R6", "recently used way kept", 128'(n), 128'(0));
    access(0, {20'd2, 8'h37, 4'h0}, 0, n);
    check(n == 20, "R6", "least recent way evicted", 128'(n), 128'(20));

    // R8 R5 R7: store miss, dirty eviction, reload
    access(1, {20'h00F00, 8'h40, 4'hC}, 32'hCAFE_0001, n);
    check(n == 20, "R8", "store miss allocates", 128'(n), 128'(20));
    access(0, {20'h00F00, 8'h40, 4'h0}, 0, n);
    check(n == 0 && rsp_rdata == init_word({20'h00F00, 8'h40, 4'h0}), "R8",
          "neighbour word from memory", 128'(rsp_rdata), 128'(init_word({20'h00F00, 8'h40, 4'h0})));
    for (int t = 0; t < 4; t++) access(0, {20'(32'h300 + t), 8'h40, 4'h0}, 0, n);
    check(n == 40, "R5", "dirty victim adds write phase", 128'(n), 128'(40));
    access(0, {20'h00F00, 8'h40, 4'hC}, 0, n);
    check(rsp_rdata == 32'hCAFE_0001, "R7", "stored word survives eviction",
          128'(rsp_rdata), 128'(32'hCAFE_0001));

    // constrained random over a few crowded sets
    for (int k = 0; k < 500; k++) begin
      logic [7:0] ix;
      case ($urandom_range(0, 2))
        0: ix = 8'h00;
        1: ix = 8'h01;
        default: ix = 8'hFF;
      endcase
      a = {20'($urandom_range(0, 6)), ix, 2'($urandom_range(0, 3)), 2'b00};
      d = $urandom;
      access(1'($urandom_range(0, 1)), a, d, n);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule